// File: doc/BRIEF.md
# Video Serializer Control Port

This block is the device end of a serial control port for a video serializer. A host talks to it over a four-wire SPI link in mode 0 (clock idles low, both sides sample on the rising edge) with 16-bit words. Every transaction is two words. The first is a command word that carries a read flag and a register address. The second is a data word: the block either shifts it out on MISO or captures it from MOSI.

Behind the port sits a small register file:

- a status word, built live from lock and standard-code inputs;
- a format-override register;
- four read-only timing counts that come in on input ports;
- a horizontal-configuration register.

When the override is enabled, the standard code in the status word is replaced by the forced code. The override and configuration values also drive output ports, so the serializer can use them.

The SPI pins are brought into the system clock domain through two-stage synchronizers. The system clock must run at least several times faster than SCLK (250 MHz against an SCLK of up to 10 MHz).

Top module: `spi_vid_regs`

## Requirements
- R1: The command word is sent first, MSB first, sampled on rising SCLK edges while chip select is low. Bit 15 = 1 selects a read and bit 15 = 0 a write. Bits 11:0 are the address, compared over all 12 bits. The 16-bit data word follows it.
- R2: On a read, the register value is shifted out on MISO MSB first. Its first bit appears after the falling SCLK edge that ends the command word, and one bit follows each later falling edge. MISO is 0 during the command word and high impedance while chip select is high.
- R3: The status register at 0x04 is read-only and has this layout:
  - bit 0: horizontal lock
  - bit 1: vertical lock
  - bit 2: standard lock
  - bits 9:5: the 5-bit standard code
  - all other bits: 0

  Its value is taken from the inputs at the end of the command word.
- R4: When bit 5 of the override register is 1, status bits 9:5 report override bits 4:0. Otherwise they report the detected code input.
- R5: The override register at 0x06 is read/write, holds all 16 bits and drives `fmt_force_o`. Writing 0 returns status to the detected code.
- R6: Addresses 0x12, 0x13, 0x14 and 0x15 return the inputs `lines_frame`, `words_line`, `act_words` and `act_lines` in that order. Writes to them are ignored.
- R7: The configuration register at 0x00 is read/write and drives `hcfg_o`.
- R8: Reads of any other address return 0x0000, and writes to them change nothing.
- R9: Raising chip select before the 16th data bit abandons the transaction and leaves every register unchanged. A write takes effect only once all 16 data bits have arrived.
- R10: After reset, the override and configuration registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-device data |
| spi_miso | output | 1 | Device-to-host data, high impedance when deselected |
| h_lock | input | 1 | Horizontal lock flag |
| v_lock | input | 1 | Vertical lock flag |
| std_lock | input | 1 | Standard lock flag |
| det_code | input | 5 | Detected video standard code |
| lines_frame | input | 16 | Lines per frame count |
| words_line | input | 16 | Words per line count |
| act_words | input | 16 | Active words per line count |
| act_lines | input | 16 | Active lines per frame count |
| fmt_force_o | output | 16 | Override register contents |
| hcfg_o | output | 16 | Configuration register contents |

## Verification
The hardest case to reach from the pins is a transaction cut short partway through the data word, after the address has been latched but before the commit edge. The bench drives its own SCLK and chip select bit by bit, so it can raise chip select after any chosen bit count. It then reads the targeted register back to confirm that nothing changed. Random sequences mix override writes with changing detected codes, so that the forced and auto paths of the status code both appear with live inputs.

// File: rtl/spi_vid_regs.sv
module spi_vid_regs #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic          h_lock,
  input  logic          v_lock,
  input  logic          std_lock,
  input  logic [CW-1:0] det_code,
  input  logic [DW-1:0] lines_frame,
  input  logic [DW-1:0] words_line,
  input  logic [DW-1:0] act_words,
  input  logic [DW-1:0] act_lines,
  output logic [DW-1:0] fmt_force_o,
  output logic [DW-1:0] hcfg_o
);
  localparam int BCW = $clog2(DW);
  localparam int FORCE_BIT = 5;
  localparam int CODE_LSB = 5;
  localparam logic [AW-1:0] A_HCFG  = AW'(12'h000);
  localparam logic [AW-1:0] A_STAT  = AW'(12'h004);
  localparam logic [AW-1:0] A_FORCE = AW'(12'h006);
  localparam logic [AW-1:0] A_CNT0  = AW'(12'h012);
  localparam logic [1:0] PH_CMD = 2'd0, PH_DATA = 2'd1, PH_DONE = 2'd2;

  logic [2:0] sclk_sr;
  logic [1:0] cs_sr, mosi_sr;
  logic rise, fall, cs_s, mosi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sr <= '0;
      cs_sr   <= '1;
      mosi_sr <= '0;
    end else begin
      sclk_sr <= {sclk_sr[1:0], spi_sclk};
      cs_sr   <= {cs_sr[0], spi_cs_n};
      mosi_sr <= {mosi_sr[0], spi_mosi};
    end

  assign rise   = sclk_sr[1] & ~sclk_sr[2];
  assign fall   = ~sclk_sr[1] & sclk_sr[2];
  assign cs_s   = cs_sr[1];
  assign mosi_s = mosi_sr[1];

  logic [1:0]     phase;
  logic [BCW-1:0] bitcnt;
  logic [DW-2:0]  rx_sh;
  logic [DW-1:0]  word, tx_sh, force_q, hcfg_q, rd_val, status;
  logic [AW-1:0]  addr_q;
  logic           rd_q, miso_q, last, addr_hit;
  logic [CW-1:0]  eff_code;

  assign word     = {rx_sh, mosi_s};
  assign last     = rise && (bitcnt == BCW'(DW-1));
  assign eff_code = force_q[FORCE_BIT] ? force_q[CW-1:0] : det_code;
  assign status   = DW'({eff_code, 2'b00, std_lock, v_lock, h_lock}) & ~(DW'(3) << 3);

  always_comb begin
    case (word[AW-1:0])
      A_HCFG:   rd_val = hcfg_q;
      A_STAT:   rd_val = status;
      A_FORCE:  rd_val = force_q;
      A_CNT0:   rd_val = lines_frame;
      A_CNT0+1: rd_val = words_line;
      A_CNT0+2: rd_val = act_words;
      A_CNT0+3: rd_val = act_lines;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= PH_CMD; bitcnt <= '0; rx_sh <= '0; tx_sh <= '0;
      addr_q <= '0; rd_q <= 1'b0; miso_q <= 1'b0;
      force_q <= '0; hcfg_q <= '0;
    end else if (cs_s) begin
      phase <= PH_CMD; bitcnt <= '0; miso_q <= 1'b0;
    end else begin
      if (rise) begin
        rx_sh  <= word[DW-2:0];
        bitcnt <= last ? '0 : bitcnt + 1'b1;
      end
      if (last && phase == PH_CMD) begin
        rd_q   <= word[DW-1];
        addr_q <= word[AW-1:0];
        tx_sh  <= word[DW-1] ? rd_val : '0;
        phase  <= PH_DATA;
      end else if (last && phase == PH_DATA) begin
        phase <= PH_DONE;
        if (!rd_q) begin
          if (addr_q == A_HCFG)  hcfg_q  <= word;
          if (addr_q == A_FORCE) force_q <= word;
        end
      end
      if (fall && phase == PH_DATA && rd_q) begin
        miso_q <= tx_sh[DW-1];
        tx_sh  <= tx_sh << 1;
      end
    end

  assign spi_miso    = cs_s ? 1'bz : miso_q;
  assign fmt_force_o = force_q;
  assign hcfg_o      = hcfg_q;

  assign addr_hit = (addr_q == A_HCFG) || (addr_q == A_STAT) || (addr_q == A_FORCE) ||
                    (addr_q >= A_CNT0 && addr_q <= A_CNT0 + 3);

  a_r2_miso_quiet_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD) |-> (miso_q == 1'b0));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && $past(phase) == PH_CMD && rd_q && !addr_hit) |-> (tx_sh == '0));

  a_r9_hcfg_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hcfg_q) |-> $past(!cs_s && rise && phase == PH_DATA));

  a_r9_force_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(force_q) |-> $past(!cs_s && rise && phase == PH_DATA));

  a_r1_cmd_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && $past(phase) == PH_CMD) |-> $past(rise));
endmodule

// File: tb/spi_vid_regs_tb_top.sv
module spi_vid_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  wire  miso;
  logic hl = 0, vl = 0, sl = 0;
  logic [4:0] det = 0;
  logic [15:0] c0 = 0, c1 = 0, c2 = 0, c3 = 0;
  logic [15:0] force_o, hcfg_o;
  logic [15:0] m_force = 0, m_hcfg = 0;
  int n_chk = 0, n_bad = 0;
  localparam int H = 6;

  always #2 clk = ~clk;

  spi_vid_regs dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .h_lock(hl), .v_lock(vl), .std_lock(sl), .det_code(det),
    .lines_frame(c0), .words_line(c1), .act_words(c2), .act_lines(c3),
    .fmt_force_o(force_o), .hcfg_o(hcfg_o));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [11:0] a);
    logic [4:0] code = m_force[5] ? m_force[4:0] : det;
    case (a)
      12'h000: return m_hcfg;
      12'h004: return {6'b0, code, 2'b00, sl, vl, hl};
      12'h006: return m_force;
      12'h012: return c0;
      12'h013: return c1;
      12'h014: return c2;
      12'h015: return c3;
      default: return 16'h0000;
    endcase
  endfunction

  // sends cbits of the command and dbits of the data word, then deselects
  task automatic xfer(input logic [15:0] cmd, input logic [15:0] wd, input int cbits,
                      input int dbits, output logic [15:0] rd, output logic quiet);
    rd = 0; quiet = 1;
    cs_n = 0; tick(H);
    for (int i = 0; i < cbits + dbits; i++) begin
      mosi = (i < 16) ? cmd[15-i] : wd[31-i];
      tick(H); sclk = 1;
      if (i < 16) begin if (miso !== 1'b0) quiet = 0; end
      else rd = {rd[14:0], miso};
      tick(H); sclk = 0;
    end
    tick(H); cs_n = 1; tick(H);
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    logic [15:0] r; logic q;
    xfer({4'h0, a}, d, 16, 16, r, q);
    if (a == 12'h000) m_hcfg = d;
    if (a == 12'h006) m_force = d;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a);
    logic [15:0] r, e; logic q;
    e = exp_rd(a);
    xfer({4'h8, a}, 16'h0, 16, 16, r, q);
    chk(req, r, e);
    if (!q) begin n_chk++; n_bad++; $display("FAIL R2: actual miso driven in command expected 0"); end
  endtask

  initial begin
    logic [15:0] r; logic q;
    tick(5); rst_n = 1; tick(5);
    // R10 reset state
    chk("R10 force reset", force_o, 16'h0);
    chk("R10 hcfg reset", hcfg_o, 16'h0);
    n_chk++; if (miso !== 1'bz) begin n_bad++; $display("FAIL R2: actual %b expected z", miso); end
    rdchk("R10 read hcfg", 12'h000);
    // R7 configuration register
    wr(12'h000, 16'h0300);
    chk("R7 hcfg port", hcfg_o, 16'h0300);
    rdchk("R7 hcfg readback", 12'h000);
    // R3 status layout, R4 auto path
    hl = 1; vl = 0; sl = 1; det = 5'h0C;
    rdchk("R3 status", 12'h004);
    // R4 forced code
    wr(12'h006, 16'h0020 | 16'h0014);
    chk("R5 force port", force_o, 16'h0034);
    rdchk("R4 forced status", 12'h004);
    wr(12'h006, 16'h0000);
    rdchk("R5 back to auto", 12'h004);
    // R6 counts read-only
    c0 = 16'h0465; c1 = 16'h0898; c2 = 16'h0780; c3 = 16'h0438;
    for (int k = 0; k < 4; k++) begin
      wr(12'h012 + 12'(k), 16'hFFFF);
      rdchk("R6 count", 12'h012 + 12'(k));
    end
    // R8 unmapped, full-width decode
    wr(12'h104, 16'hABCD);
    rdchk("R8 unmapped 0x104", 12'h104);
    rdchk("R8 unmapped 0xFFF", 12'hFFF);
    wr(12'h004, 16'hFFFF);
    rdchk("R8 status write ignored", 12'h004);
    chk("R8 hcfg untouched", hcfg_o, m_hcfg);
    // R9 abort in data word and in command word
    xfer({4'h0, 12'h000}, 16'h1234, 16, 15, r, q);
    chk("R9 abort data hcfg", hcfg_o, m_hcfg);
    rdchk("R9 abort data readback", 12'h000);
    xfer({4'h0, 12'h006}, 16'h0025, 9, 0, r, q);
    chk("R9 abort cmd force", force_o, m_force);
    xfer({4'h0, 12'h006}, 16'h0025, 16, 0, r, q);
    chk("R9 no data word", force_o, m_force);
    // R1/R2 random mix
    void'($urandom(32'd1234));
    for (int it = 0; it < 80; it++) begin
      logic [11:0] a;
      hl = 1'($urandom); vl = 1'($urandom); sl = 1'($urandom); det = 5'($urandom);
      c0 = 16'($urandom); c1 = 16'($urandom); c2 = 16'($urandom); c3 = 16'($urandom);
      case ($urandom % 6)
        0: a = 12'h000; 1: a = 12'h004; 2: a = 12'h006;
        3: a = 12'h012 + 12'($urandom % 4);
        default: a = 12'($urandom);
      endcase
      if ($urandom % 2) begin
        wr(a, 16'($urandom));
        chk("R1 random write force", force_o, m_force);
        chk("R1 random write hcfg", hcfg_o, m_hcfg);
      end else rdchk("R2 random read", a);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule